// File: doc/BRIEF.md
# Reverse-Subtract Skip-on-Borrow Processor Core

This block is a processor core whose only instruction is a two-operand reverse subtract. An instruction occupies two consecutive memory words: the first holds operand address `a`, the second holds operand address `b`. The core reads both operands. It computes `mem[a] - mem[b] - borrow` and writes the result back to `a`. When that result is negative, the core skips the instruction that follows. There is no opcode and no branch target. All control flow comes from that skip. A borrow bit is kept from one instruction to the next, so a program can chain subtractions over several words.

The core talks to one single-port synchronous memory. The read data for an address appears one cycle after the address is driven. Writes take effect at the clock edge while the write enable is high. An instruction runs in five cycles: two operand-address fetches, two operand reads, and one write-back cycle. The borrow state and a halt indication are brought out as ports. A program ends with an instruction whose two addresses are both all-ones.

Top module: `rssb_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `halted` is 0, `borrowOut` is 0, `memWrEn` is 0, and `memAddr` is 0, which is the first instruction fetch.
- R2: The instruction at program counter `pc` is the word at `pc` followed by the word at `pc+1`. Only the low `ADDR_W` bits of each word are used as the addresses `a` and `b`. The upper bits are ignored.
- R3: An executed instruction writes `mem[a] - mem[b] - borrow` to location `a`, wrapped to `DATA_W` bits.
- R4: The new borrow is bit `DATA_W-1` of the value written. It replaces the old borrow only when an instruction executes, and `borrowOut` shows it.
- R5: After an executed instruction, `pc` advances by 4 when the new borrow is 1 and by 2 when it is 0, modulo 2^`ADDR_W`. A skipped instruction, halt or not, causes no write.
- R6: An instruction whose `a` and `b` fields are both all-ones stops the core. It makes no write and leaves the borrow unchanged. `halted` then stays 1 until reset, and no further writes happen.
- R7: Each executed instruction makes exactly one memory write. From the release of reset to `halted`, the run lasts 5 cycles per executed instruction plus 3 cycles for the halting instruction.
- R8: When `a` equals `b`, the value written is `-borrow`. That is 0 with the borrow clear, or all-ones with the borrow set, which sets the borrow again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | ADDR_W | Memory word address for the read or the write |
| memWrEn | output | 1 | Write strobe for the current cycle |
| memWrData | output | DATA_W | Write data |
| memRdData | input | DATA_W | Read data for the address of the previous cycle |
| borrowOut | output | 1 | Current borrow state |
| halted | output | 1 | Core has reached a halt instruction |

## Verification
Directed programs cover specific cases:
- A plain positive difference, which leaves the borrow clear and causes no skip.
- A negative result, which must skip a live instruction and feed a borrow of 1 into the instruction after it.
- An instruction with equal addresses, run with the borrow set.
- The most negative word minus one, which shows that the borrow follows the wrapped sign and not the true sign.
- A skip over a halt instruction, which shows that a skipped halt does not stop the core.

Constrained random programs use random data words and random upper bits in the address words. Their final memory image, final borrow, write count and cycle count are compared against a reference model in the bench. A wrong skip distance, a stale borrow or a misread address field each changes those values.

// File: rtl/rssb_pkg.sv
package rssb_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_READ_A,
    ST_READ_B,
    ST_EXEC,
    ST_HALT
  } coreState_t;

  typedef enum logic [1:0] {
    ADDR_PC,
    ADDR_PC_NEXT,
    ADDR_OPND_A,
    ADDR_OPND_B
  } addrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     ldAddrA;
    logic     ldAddrB;
    logic     ldOpA;
    logic     commit;
  } ctrlStrobe_t;

endpackage

// File: rtl/rssb_subtract.sv
module rssb_subtract #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic              borrowIn,
  output logic [DATA_W-1:0] diff,
  output logic              negative
);

  localparam int SIGN_BIT = DATA_W - 1;

  always_comb begin
    diff     = minuend - subtrahend - {{(DATA_W-1){1'b0}}, borrowIn};
    negative = diff[SIGN_BIT];
  end

endmodule

// File: rtl/rssb_control.sv
module rssb_control
  import rssb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltSeen,
  output ctrlStrobe_t strobe,
  output logic        halted
);

  coreState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH_A;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '{addrSel: ADDR_PC, ldAddrA: 1'b0, ldAddrB: 1'b0,
                  ldOpA: 1'b0, commit: 1'b0};
    stateNext = state;
    unique case (state)
      ST_FETCH_A: begin
        strobe.addrSel = ADDR_PC;
        stateNext      = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        strobe.addrSel = ADDR_PC_NEXT;
        strobe.ldAddrA = 1'b1;
        stateNext      = ST_READ_A;
      end
      ST_READ_A: begin
        strobe.addrSel = ADDR_OPND_A;
        strobe.ldAddrB = 1'b1;
        stateNext      = haltSeen ? ST_HALT : ST_READ_B;
      end
      ST_READ_B: begin
        strobe.addrSel = ADDR_OPND_B;
        strobe.ldOpA   = 1'b1;
        stateNext      = ST_EXEC;
      end
      ST_EXEC: begin
        strobe.addrSel = ADDR_OPND_A;
        strobe.commit  = 1'b1;
        stateNext      = ST_FETCH_A;
      end
      ST_HALT: begin
        stateNext = ST_HALT;
      end
      default: stateNext = ST_FETCH_A;
    endcase
  end

  assign halted = (state == ST_HALT);

  // Once stopped, the core never leaves the halt state before reset.
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // A stopped core makes no writes.
  p_halted_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !strobe.commit);

  // Write-backs are separated by the fetch and read cycles.
  p_commit_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);

  // Only one kind of load happens in any cycle.
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.ldAddrA, strobe.ldAddrB, strobe.ldOpA, strobe.commit}) <= 1);

endmodule

// File: rtl/rssb_datapath.sv
module rssb_datapath
  import rssb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              haltSeen,
  output logic              borrowQ
);

  localparam logic [ADDR_W-1:0] STEP_NORMAL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_SKIP   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] PC_INIT     = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] addrA;
  logic [ADDR_W-1:0] addrB;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] diff;
  logic              negative;

  rssb_subtract #(.DATA_W(DATA_W)) u_sub (
    .minuend   (opA),
    .subtrahend(rdData),
    .borrowIn  (borrowQ),
    .diff      (diff),
    .negative  (negative)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= PC_INIT;
      addrA   <= '0;
      addrB   <= '0;
      opA     <= '0;
      borrowQ <= 1'b0;
    end else begin
      if (strobe.ldAddrA) addrA <= rdData[ADDR_W-1:0];
      if (strobe.ldAddrB) addrB <= rdData[ADDR_W-1:0];
      if (strobe.ldOpA)   opA   <= rdData;
      if (strobe.commit) begin
        borrowQ <= negative;
        pc      <= pc + (negative ? STEP_SKIP : STEP_NORMAL);
      end
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_PC:      memAddr = pc;
      ADDR_PC_NEXT: memAddr = pc + ADDR_W'(1);
      ADDR_OPND_A:  memAddr = addrA;
      ADDR_OPND_B:  memAddr = addrB;
      default:      memAddr = pc;
    endcase
  end

  assign wrData   = diff;
  assign haltSeen = (&addrA) && (&rdData[ADDR_W-1:0]);

  // The program counter moves by the skip distance chosen by the borrow just stored.
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ((pc - $past(pc)) == (borrowQ ? STEP_SKIP : STEP_NORMAL)));

  // The program counter is held between write-backs.
  p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(pc));

  // The borrow changes only when an instruction completes.
  p_borrow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(borrowQ));

  // The stored borrow equals the sign of the word that was written.
  p_borrow_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (borrowQ == $past(wrData[DATA_W-1])));

endmodule

// File: rtl/rssb_core.sv
module rssb_core
  import rssb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              borrowOut,
  output logic              halted
);

  ctrlStrobe_t strobe;
  logic        haltSeen;

  rssb_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .haltSeen(haltSeen),
    .strobe  (strobe),
    .halted  (halted)
  );

  rssb_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdData  (memRdData),
    .memAddr (memAddr),
    .wrData  (memWrData),
    .haltSeen(haltSeen),
    .borrowQ (borrowOut)
  );

  assign memWrEn = strobe.commit;

endmodule

// File: tb/tb_rssb_core.sv
`timescale 1ns/1ps
module tb_rssb_core;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memWrEn;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData = '0;
  logic          borrowOut;
  logic          halted;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] refMem [DEPTH];

  int checks = 0;
  int fails  = 0;
  int wrCount = 0;
  int cycCount = 0;
  int expExec;
  logic expBorrow;

  always #4 clk = ~clk;

  rssb_core #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData),
    .borrowOut(borrowOut), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
    if (!rstN) begin
      wrCount  <= 0;
      cycCount <= 0;
    end else begin
      if (memWrEn) wrCount <= wrCount + 1;
      if (!halted) cycCount <= cycCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic putInstr(input int at, input int a, input int b);
    mem[at]   = DW'(a);
    mem[at+1] = DW'(b);
  endtask

  // Reference model built from R2-R6.
  task automatic refRun();
    logic [AW-1:0] pc = '0;
    logic          br = 1'b0;
    logic [AW-1:0] a, b;
    logic [DW-1:0] r;
    expExec = 0;
    for (int step = 0; step < 1000; step++) begin
      a = refMem[pc][AW-1:0];
      b = refMem[AW'(pc + 1)][AW-1:0];
      if (&a && &b) break;
      r = refMem[a] - refMem[b] - DW'(br);
      refMem[a] = r;
      br = r[DW-1];
      pc = pc + (br ? AW'(4) : AW'(2));
      expExec++;
    end
    expBorrow = br;
  endtask

  task automatic runProg(input string name);
    int cyc;
    int mism;
    int firstBad;
    int wrAtHalt;
    rstN = 1'b0;
    for (int i = 0; i < DEPTH; i++) refMem[i] = mem[i];
    refRun();
    repeat (2) @(negedge clk);
    check(halted == 1'b0 && borrowOut == 1'b0 && memWrEn == 1'b0, "R1",
          {name, " in reset"}, {halted, borrowOut, memWrEn}, 0);
    rstN = 1'b1;
    #1;
    check(memAddr == '0 && memWrEn == 1'b0 && halted == 1'b0 && borrowOut == 1'b0,
          "R1", {name, " first fetch"}, {memAddr, memWrEn, halted, borrowOut}, 0);
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(halted == 1'b1, "R6", {name, " reaches halt"}, halted, 1);
    mism = 0;
    firstBad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== refMem[i]) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    if (firstBad < 0) firstBad = 0;
    check(mism == 0, "R3", {name, " memory image"}, mem[firstBad], refMem[firstBad]);
    check(borrowOut == expBorrow, "R4", {name, " final borrow"}, borrowOut, expBorrow);
    check(wrCount == expExec, "R7", {name, " write count"}, wrCount, expExec);
    check(cycCount == 5 * expExec + 3, "R7", {name, " cycle count"}, cycCount, 5 * expExec + 3);
    wrAtHalt = wrCount;
    repeat (8) @(negedge clk);
    check(halted == 1'b1 && wrCount == wrAtHalt && borrowOut == expBorrow, "R6",
          {name, " stays halted"}, wrCount, wrAtHalt);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0017);

    // R3 plain positive difference, no skip.
    clearMem();
    putInstr(0, 128, 129);
    putInstr(2, 16'hFFFF, 16'hFFFF);
    mem[128] = 16'd100; mem[129] = 16'd30;
    runProg("positive");
    check(mem[128] == 16'd70, "R3", "100-30", mem[128], 16'd70);
    check(borrowOut == 1'b0, "R4", "positive borrow", borrowOut, 0);

    // R5 negative result skips the next instruction; the borrow feeds the third one.
    clearMem();
    putInstr(0, 128, 129);
    putInstr(2, 130, 129);
    putInstr(4, 131, 129);
    putInstr(6, 16'hFFFF, 16'hFFFF);
    mem[128] = 16'd5; mem[129] = 16'd9; mem[130] = 16'd7; mem[131] = 16'd20;
    runProg("skip");
    check(mem[128] == 16'hFFFC, "R3", "5-9", mem[128], 16'hFFFC);
    check(mem[130] == 16'd7, "R5", "skipped instr untouched", mem[130], 16'd7);
    check(mem[131] == 16'd10, "R4", "borrow chained 20-9-1", mem[131], 16'd10);
    check(wrCount == 2, "R5", "skip write count", wrCount, 2);

    // R8 equal addresses with borrow set; R6 skipped halt does not stop the core.
    clearMem();
    putInstr(0, 128, 129);
    putInstr(2, 16'hFFFF, 16'hFFFF);
    putInstr(4, 130, 130);
    putInstr(6, 131, 131);
    putInstr(8, 16'hFFFF, 16'hFFFF);
    mem[128] = 16'd0; mem[129] = 16'd1; mem[130] = 16'd55; mem[131] = 16'd9;
    runProg("same-addr");
    check(mem[130] == 16'hFFFF, "R8", "a==b with borrow", mem[130], 16'hFFFF);
    check(mem[131] == 16'd9, "R5", "skip after a==b", mem[131], 16'd9);
    check(borrowOut == 1'b1, "R8", "borrow after a==b", borrowOut, 1);

    // R4 borrow follows the wrapped sign; R2 upper bits of address words ignored.
    clearMem();
    putInstr(0, 16'hA580, 16'h3C81);
    putInstr(2, 16'h12FF, 16'h00FF);
    mem[128] = 16'h8000; mem[129] = 16'd1;
    runProg("wrap");
    check(mem[128] == 16'h7FFF, "R4", "min minus one", mem[128], 16'h7FFF);
    check(borrowOut == 1'b0, "R4", "wrapped sign borrow", borrowOut, 0);

    // Random programs checked against the reference model (R2 R3 R4 R5 R7 R8).
    for (int t = 0; t < 40; t++) begin
      int n;
      int a;
      int b;
      clearMem();
      n = 3 + int'($urandom_range(9));
      for (int i = 0; i < n; i++) begin
        a = 128 + int'($urandom_range(63));
        b = ($urandom_range(7) == 0) ? a : 128 + int'($urandom_range(63));
        putInstr(2 * i, {8'($urandom), 8'(a)}, {8'($urandom), 8'(b)});
      end
      for (int i = 0; i < 4; i++) mem[2 * n + i] = 16'hFFFF;
      for (int i = 128; i < 192; i++)
        mem[i] = ($urandom_range(1) == 0) ? DW'($urandom_range(40)) : DW'($urandom);
      runProg($sformatf("random%0d", t));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule